// File: doc/BRIEF.md
# Periodic Interrupt and Pulse Generator

This block turns the timekeeping chain's periodic strobes into a host interrupt flag and an open-drain periodic output. A two-bit period select picks one of four strobes: a fast divider tap at 64 Hz, or the once-per-second, once-per-minute or once-per-hour carries. When the chosen strobe fires, the block raises its flag. In interrupt mode the flag stays up until the host clears it. In standard mode the flag drops by itself after a fixed pulse width of half a fast-tap period (1/128 s), which the parameter `PULSE_CYCLES` gives in clock cycles.

The output pin is modelled as an active-low open-drain level `std_n`. While the flag is up and the mask is off, the pin is pulled low. Otherwise it is released high. A set mask releases the pin and also stops new strobes from raising the flag. The host can only clear the flag and never sets it. All strobe inputs are single-cycle pulses in the block's clock domain, and the carries line up with fast-tap edges. This means a standard-mode pulse is timed from the fast-tap phase. All control and status pins are plain levels or pulses: the block has no data stream and applies no back-pressure.

Top module: `periodic_pulse_gen`

## Requirements
- R1: After reset `irq_flag` is 0 and `std_n` is 1.
- R2: `period_sel` picks the strobe: 2'b00 the 64 Hz tap, 2'b01 the seconds carry, 2'b10 the minutes carry, 2'b11 the hours carry; a strobe that is not selected leaves `irq_flag` unchanged.
- R3: With `irq_mode`=1 and `out_mask`=0, a selected strobe sets `irq_flag` at the next clock edge, and the flag then stays 1 until a host clear.
- R4: A `flag_clr` pulse with no selected unmasked strobe in the same cycle makes `irq_flag` 0 at the next edge; if a selected unmasked strobe arrives in the same cycle, the set wins.
- R5: With `irq_mode`=0, a selected unmasked strobe raises `irq_flag` for exactly `PULSE_CYCLES` clock cycles, after which it clears without host action.
- R6: `std_n` is 0 exactly when `irq_flag` is 1 and `out_mask` is 0, and is 1 otherwise; raising `out_mask` releases the pin without altering `irq_flag`.
- R7: While `out_mask` is 1, a selected strobe does not set `irq_flag`.
- R8: In standard mode a selected unmasked strobe that arrives while a pulse is running restarts the width, so the flag stays 1 for `PULSE_CYCLES` cycles counted from the latest strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_64hz | input | 1 | One-cycle strobe from the 64 Hz divider tap |
| carry_sec | input | 1 | One-cycle seconds carry |
| carry_min | input | 1 | One-cycle minutes carry |
| carry_hour | input | 1 | One-cycle hours carry |
| period_sel | input | 2 | Period select (encoding in R2) |
| irq_mode | input | 1 | 1 = latched interrupt, 0 = self-clearing standard pulse |
| out_mask | input | 1 | 1 = pin released and new strobes ignored |
| flag_clr | input | 1 | One-cycle host clear of the flag |
| irq_flag | output | 1 | Interrupt flag, readable by the host |
| std_n | output | 1 | Open-drain pin level, 0 = pulled low |

## Verification
The assertions assume that strobes and the host clear are single-cycle pulses sampled on the block clock. They also assume that `period_sel`, `irq_mode` and `out_mask` are plain levels whose changes take effect at the next edge. The stimulus meets this by driving every input just after a rising edge and by pulsing each strobe for one cycle. Random phases change the mode, select and mask only now and then, and strobes fire often enough to overlap running standard pulses. This overlap exercises the retrigger path and the cases where a clear and a set land in the same cycle.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [1:0] {
    PER_FAST = 2'b00,
    PER_SEC  = 2'b01,
    PER_MIN  = 2'b10,
    PER_HOUR = 2'b11
  } period_e;

  localparam int unsigned N_SRC = 4;
endpackage

// File: rtl/prd_src_mux.sv
module prd_src_mux
  import prd_pkg::*;
(
  input  logic [N_SRC-1:0] src_vec,
  input  logic [1:0]       period_sel,
  output logic             sel_evt
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = src_vec[g] && (period_sel == 2'(g));
  end

  assign sel_evt = |hit;
endmodule

// File: rtl/prd_flag_core.sv
module prd_flag_core #(
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_evt,
  input  logic irq_mode,
  input  logic out_mask,
  input  logic flag_clr,
  output logic flag_q
);
  localparam int unsigned CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

  logic [CW-1:0] left_q;
  logic          set_ok;
  logic          expire;

  assign set_ok = sel_evt && !out_mask;
  assign expire = !irq_mode && flag_q && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      left_q <= '0;
    end else if (set_ok) begin
      flag_q <= 1'b1;
      left_q <= LOAD;
    end else if (flag_clr || expire) begin
      flag_q <= 1'b0;
    end else if (!irq_mode && flag_q) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/prd_pin_drv.sv
module prd_pin_drv (
  input  logic flag_q,
  input  logic out_mask,
  output logic pin_n
);
  logic pull_low;
  assign pull_low = flag_q & ~out_mask;
  assign pin_n    = ~pull_low;
endmodule

// File: rtl/periodic_pulse_gen.sv
module periodic_pulse_gen
  import prd_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_64hz,
  input  logic       carry_sec,
  input  logic       carry_min,
  input  logic       carry_hour,
  input  logic [1:0] period_sel,
  input  logic       irq_mode,
  input  logic       out_mask,
  input  logic       flag_clr,
  output logic       irq_flag,
  output logic       std_n
);
  logic [N_SRC-1:0] src_vec;
  logic             sel_evt;

  assign src_vec[PER_FAST] = tick_64hz;
  assign src_vec[PER_SEC]  = carry_sec;
  assign src_vec[PER_MIN]  = carry_min;
  assign src_vec[PER_HOUR] = carry_hour;

  prd_src_mux u_mux (
    .src_vec    (src_vec),
    .period_sel (period_sel),
    .sel_evt    (sel_evt)
  );

  prd_flag_core #(.PULSE_CYCLES(PULSE_CYCLES)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_evt  (sel_evt),
    .irq_mode (irq_mode),
    .out_mask (out_mask),
    .flag_clr (flag_clr),
    .flag_q   (irq_flag)
  );

  prd_pin_drv u_pin (
    .flag_q   (irq_flag),
    .out_mask (out_mask),
    .pin_n    (std_n)
  );
endmodule

// File: rtl/prd_checker.sv
module prd_checker (
  input logic clk,
  input logic rst_n,
  input logic sel_evt,
  input logic irq_mode,
  input logic out_mask,
  input logic flag_clr,
  input logic irq_flag,
  input logic std_n
);
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_evt && !out_mask) |=> irq_flag);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && irq_flag && !flag_clr) |=> irq_flag);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(sel_evt && !out_mask)) |=> !irq_flag);

  p_mask_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_mask |-> std_n);

  p_low_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !std_n |-> irq_flag);

  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mask && !irq_flag) |=> !irq_flag);
endmodule

bind periodic_pulse_gen prd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_evt  (sel_evt),
  .irq_mode (irq_mode),
  .out_mask (out_mask),
  .flag_clr (flag_clr),
  .irq_flag (irq_flag),
  .std_n    (std_n)
);

// File: tb/periodic_pulse_gen_tb.sv
module periodic_pulse_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned PW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_64hz = 1'b0, carry_sec = 1'b0, carry_min = 1'b0, carry_hour = 1'b0;
  logic [1:0] period_sel = 2'b00;
  logic       irq_mode = 1'b1, out_mask = 1'b0, flag_clr = 1'b0;
  logic       irq_flag, std_n;

  int n_chk = 0;
  int n_bad = 0;
  bit m_flag = 1'b0;
  int m_left = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_pulse_gen #(.PULSE_CYCLES(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_64hz(tick_64hz), .carry_sec(carry_sec),
    .carry_min(carry_min), .carry_hour(carry_hour), .period_sel(period_sel),
    .irq_mode(irq_mode), .out_mask(out_mask), .flag_clr(flag_clr),
    .irq_flag(irq_flag), .std_n(std_n)
  );

  function automatic bit sel_strobe(logic [1:0] s, logic f, logic sc, logic mi, logic hr);
    case (s)
      2'b00:   return f;
      2'b01:   return sc;
      2'b10:   return mi;
      default: return hr;
    endcase
  endfunction

  function automatic bit exp_pin(bit flag, logic mask);
    return !(flag && !mask);
  endfunction

  task automatic model_edge();
    bit ev;
    ev = sel_strobe(period_sel, tick_64hz, carry_sec, carry_min, carry_hour);
    if (ev && !out_mask) begin
      m_flag = 1'b1;
      m_left = PW - 1;
    end else if (flag_clr) begin
      m_flag = 1'b0;
    end else if (!irq_mode && m_flag) begin
      if (m_left == 0) m_flag = 1'b0;
      else m_left--;
    end
  endtask

  task automatic check(string tag_f, string tag_p);
    n_chk++;
    if (irq_flag !== m_flag) begin
      n_bad++;
      $display("FAIL %s irq_flag got %0b exp %0b at %0t", tag_f, irq_flag, m_flag, $time);
    end
    n_chk++;
    if (std_n !== exp_pin(m_flag, out_mask)) begin
      n_bad++;
      $display("FAIL %s std_n got %0b exp %0b at %0t", tag_p, std_n,
               exp_pin(m_flag, out_mask), $time);
    end
  endtask

  // one clock: model the edge, let it pass, check, then drop the pulses
  task automatic step(string tag);
    model_edge();
    @(posedge clk);
    #1;
    check(tag, "R6");
    tick_64hz = 1'b0; carry_sec = 1'b0; carry_min = 1'b0; carry_hour = 1'b0;
    flag_clr = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic do_clear();
    flag_clr = 1'b1;
    step("R4");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h2468_ace1;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "R1");
    rst_n = 1'b1;
    idle(2, "R1");

    // latched interrupt, seconds source
    irq_mode = 1'b1; period_sel = 2'b01;
    carry_sec = 1'b1; step("R3");
    idle(6, "R3");
    do_clear();
    carry_sec = 1'b1; flag_clr = 1'b1; step("R4");
    do_clear();

    // unselected strobes ignored, each selection works
    tick_64hz = 1'b1; step("R2");
    carry_min = 1'b1; step("R2");
    carry_hour = 1'b1; step("R2");
    period_sel = 2'b10; carry_min = 1'b1; step("R2"); do_clear();
    period_sel = 2'b11; carry_sec = 1'b1; step("R2");
    carry_hour = 1'b1; step("R2"); do_clear();
    period_sel = 2'b00; tick_64hz = 1'b1; step("R2"); do_clear();

    // mask
    out_mask = 1'b1; tick_64hz = 1'b1; step("R7");
    idle(2, "R7");
    out_mask = 1'b0; tick_64hz = 1'b1; step("R6");
    out_mask = 1'b1; step("R6");
    out_mask = 1'b0; step("R6");
    do_clear();

    // standard pulse width and retrigger
    irq_mode = 1'b0;
    tick_64hz = 1'b1; step("R5");
    idle(PW + 3, "R5");
    tick_64hz = 1'b1; step("R8");
    idle(4, "R8");
    tick_64hz = 1'b1; step("R8");
    idle(PW + 3, "R8");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0) irq_mode = 1'($urandom);
      if ($urandom % 30 == 0) period_sel = 2'($urandom);
      if ($urandom % 25 == 0) out_mask = ($urandom % 4 == 0);
      tick_64hz  = ($urandom % 6 == 0);
      carry_sec  = ($urandom % 9 == 0);
      carry_min  = ($urandom % 12 == 0);
      carry_hour = ($urandom % 15 == 0);
      flag_clr   = ($urandom % 10 == 0);
      step(irq_mode ? "R3" : "R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule